// File: doc/BRIEF.md
# Wake-Up Event Flag Controller

This block keeps three pending wake-up flags for a low-power subsystem. The sources are a real-time-counter compare channel, a software-raised event and one programmable wake source. Each source gives a single-cycle pulse in the block clock domain. That pulse sets its sticky flag, and the flag stays set until software clears it. A wake request output is raised whenever any flag is pending.

Clearing works by level, not by pulse. Software holds a clear bit high until it reads the matching flag as zero. While the bit is held, the flag is forced to zero and new events for that flag are lost.

Two rules tie the clears to the programmable source selection:
- If the programmable source is the same compare channel, the compare clear also empties the programmable flag.
- The programmable clear acts only when the selected source is an IO line whose input enable is set.

The selection code works as follows. Value 0 is the compare channel. Values 1 to NUM_IO are IO lines 0 to NUM_IO-1. Higher values are other, non-IO sources.

Top module: `wakeup_flag_ctrl`

## Requirements
- R1: Flag vector layout is bit 2 = compare channel, bit 1 = software event, bit 0 = programmable source. A synchronous active-low reset returns all flags to 0, and events applied during reset are ignored.
- R2: An event pulse with its clear low sets its flag on the next clock edge. The flag then stays set on later cycles without further events.
- R3: The compare flag sets on every compare pulse, whatever the programmable source selection.
- R4: While a clear bit (clr_i bit n clears flag bit n) is high, its flag reads 0 from the next edge on and stays 0 for as long as the bit is held.
- R5: An event arriving while its clear is held is dropped, so the flag stays 0 after release. An event after release sets the flag.
- R6: With prog_sel_i = 0, holding clr_i[2] also clears flag bit 0. With any other selection, clr_i[2] leaves flag bit 0 unchanged.
- R7: clr_i[0] clears flag bit 0 only when prog_sel_i is in 1..NUM_IO and io_in_en_i[prog_sel_i-1] is 1. Otherwise it has no effect on the flag and does not block new programmable events.
- R8: wake_req_o is the OR of the three flags, valid in the same cycle as the flags.
- R9: A clear touches no flag other than its own, apart from the R6 cross-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtc_evt_i | input | 1 | Compare channel event pulse |
| sw_evt_i | input | 1 | Software event pulse |
| prog_evt_i | input | 1 | Programmable source event pulse (already selected outside) |
| prog_sel_i | input | SEL_W | Programmable source code: 0 compare, 1..NUM_IO IO line, above non-IO |
| io_in_en_i | input | NUM_IO | Input enable of each IO line |
| clr_i | input | 3 | Level clear bits, one per flag bit |
| flags_o | output | 3 | Pending flags |
| wake_req_o | output | 1 | Any flag pending |

## Verification
The assertions take event inputs as single pulses that may arrive in any cycle, including cycles where a clear is held. They also assume prog_sel_i and io_in_en_i are stable around the cycle a clear is judged. The stimulus drives every input half a cycle before the sampling edge, so selection and clears never change at the edge itself. Some steps deliberately raise an event while the clear is held, to exercise the dropped-event rule. Selections are chosen to reach the compare code, the first and last IO codes and a non-IO code.

// File: rtl/wuf_pkg.sv
// Package: shared flag indices and vector type for the wake-up flag controller.
// Assumes three flags; index order is decoded by software and must not move.
package wuf_pkg;
    localparam int NUM_FLAGS = 3;
    localparam int FLG_PROG  = 0;
    localparam int FLG_SW    = 1;
    localparam int FLG_RTC   = 2;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/wuf_clear_decode.sv
// Module: wuf_clear_decode
// Turns the held clear bits into per-flag block levels. It applies the
// compare-to-programmable cross-clear and the IO-only programmable clear.
// Assumes selection code 0 = compare channel, 1..NUM_IO = IO line code-1.
module wuf_clear_decode
    import wuf_pkg::*;
#(
    parameter int NUM_IO = 4,
    parameter int SEL_W  = 4
) (
    input  flag_vec_t         clr_i,
    input  logic [SEL_W-1:0]  prog_sel_i,
    input  logic [NUM_IO-1:0] io_in_en_i,
    output flag_vec_t         block_o
);
    localparam logic [SEL_W-1:0] SEL_RTC = '0;

    logic io_clr_ok;
    logic rtc_is_prog;

    // Find whether the selected source is an enabled IO line.
    always_comb begin
        io_clr_ok = 1'b0;
        for (int k = 0; k < NUM_IO; k++) begin
            if (prog_sel_i == SEL_W'(k + 1) && io_in_en_i[k]) begin
                io_clr_ok = 1'b1;
            end
        end
    end

    // Detect the compare channel serving as the programmable source.
    always_comb begin
        rtc_is_prog = (prog_sel_i == SEL_RTC);
    end

    // Build the block level of each flag.
    always_comb begin
        block_o           = '0;
        block_o[FLG_RTC]  = clr_i[FLG_RTC];
        block_o[FLG_SW]   = clr_i[FLG_SW];
        block_o[FLG_PROG] = (clr_i[FLG_PROG] && io_clr_ok)
                          || (clr_i[FLG_RTC] && rtc_is_prog);
    end
endmodule

// File: rtl/wuf_flag_cell.sv
// Module: wuf_flag_cell
// One sticky pending flag. A block level wins over an event and forces the
// flag to 0. Otherwise an event pulse sets it and it holds.
// Assumes evt_i is a single-cycle pulse in the clk domain.
module wuf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic block_i,
    output logic flag_o
);
    // Flag register: reset, block, set, hold in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (block_i) begin
            flag_o <= 1'b0;
        end else if (evt_i) begin
            flag_o <= 1'b1;
        end
    end

    AST_BLOCK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |=> !flag_o); // R4
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !block_i) |=> flag_o); // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i && !block_i) |=> $stable(flag_o)); // R2
    AST_DROP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && block_i) |=> !flag_o); // R5
endmodule

// File: rtl/wakeup_flag_ctrl.sv
// Module: wakeup_flag_ctrl (top)
// Three pending wake flags with level-held clears and a wake request.
// Assumes single-cycle event pulses in the clk domain and a synchronous
// active-low reset.
module wakeup_flag_ctrl
    import wuf_pkg::*;
#(
    parameter int NUM_IO = 4,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_evt_i,
    input  logic              sw_evt_i,
    input  logic              prog_evt_i,
    input  logic [SEL_W-1:0]  prog_sel_i,
    input  logic [NUM_IO-1:0] io_in_en_i,
    input  logic [2:0]        clr_i,
    output logic [2:0]        flags_o,
    output logic              wake_req_o
);
    localparam logic [SEL_W-1:0] SEL_RTC = '0;
    localparam logic [SEL_W-1:0] SEL_LAST_IO = SEL_W'(NUM_IO);

    flag_vec_t evt_vec;
    flag_vec_t block_vec;
    flag_vec_t flag_vec;

    // Collect the event pulses in flag order.
    always_comb begin
        evt_vec           = '0;
        evt_vec[FLG_RTC]  = rtc_evt_i;
        evt_vec[FLG_SW]   = sw_evt_i;
        evt_vec[FLG_PROG] = prog_evt_i;
    end

    wuf_clear_decode #(
        .NUM_IO (NUM_IO),
        .SEL_W  (SEL_W)
    ) clr_dec_i (
        .clr_i      (clr_i),
        .prog_sel_i (prog_sel_i),
        .io_in_en_i (io_in_en_i),
        .block_o    (block_vec)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        wuf_flag_cell cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_vec[g]),
            .block_i (block_vec[g]),
            .flag_o  (flag_vec[g])
        );
    end

    // Drive the outputs from the flag cells.
    always_comb begin
        flags_o    = flag_vec;
        wake_req_o = |flag_vec;
    end

    AST_CROSS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[FLG_RTC] && prog_sel_i == SEL_RTC) |=> !flags_o[FLG_PROG]); // R6
    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[FLG_PROG] && !clr_i[FLG_PROG] && prog_sel_i != SEL_RTC)
        |=> flags_o[FLG_PROG]); // R6
    AST_IO_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[FLG_PROG] && !clr_i[FLG_RTC]
         && (prog_sel_i > SEL_LAST_IO || prog_sel_i == SEL_RTC))
        |=> flags_o[FLG_PROG]); // R7
    AST_RTC_ANY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_evt_i && !clr_i[FLG_RTC]) |=> flags_o[FLG_RTC]); // R3
    AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req_o) |-> $past(rtc_evt_i || sw_evt_i || prog_evt_i)); // R8
    AST_SW_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[FLG_SW] && !clr_i[FLG_SW]) |=> flags_o[FLG_SW]); // R9
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (flags_o == 3'b000)); // R1
endmodule

// File: tb/wakeup_flag_ctrl_tb.sv
// Bench: a vector table walked by one loop, then directed reset and
// long-hold clear tests. Inputs change on the falling edge and outputs are
// sampled 1 ns after the rising edge.
module wakeup_flag_ctrl_tb_top;
    localparam int NUM_IO = 4;
    localparam int SEL_W  = 4;
    localparam int NVEC   = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rtc_evt_i = 1'b0;
    logic              sw_evt_i = 1'b0;
    logic              prog_evt_i = 1'b0;
    logic [SEL_W-1:0]  prog_sel_i = '0;
    logic [NUM_IO-1:0] io_in_en_i = '0;
    logic [2:0]        clr_i = '0;
    logic [2:0]        flags_o;
    logic              wake_req_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wakeup_flag_ctrl #(.NUM_IO(NUM_IO), .SEL_W(SEL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rtc_evt_i(rtc_evt_i), .sw_evt_i(sw_evt_i),
        .prog_evt_i(prog_evt_i), .prog_sel_i(prog_sel_i),
        .io_in_en_i(io_in_en_i), .clr_i(clr_i),
        .flags_o(flags_o), .wake_req_o(wake_req_o)
    );

    // Entry: {evt rtc,sw,prog}, sel, io enables, clr, expected flags after edge.
    localparam logic [16:0] VEC [NVEC] = '{
        {3'b100, 4'd5, 4'b0000, 3'b000, 3'b100}, // R3 compare sets, not selected
        {3'b010, 4'd5, 4'b0000, 3'b000, 3'b110}, // R2 software sets
        {3'b001, 4'd5, 4'b0000, 3'b000, 3'b111}, // R2 programmable sets
        {3'b000, 4'd5, 4'b1111, 3'b001, 3'b111}, // R7 non-IO source: no clear
        {3'b000, 4'd2, 4'b0000, 3'b001, 3'b111}, // R7 IO enable off: no clear
        {3'b000, 4'd2, 4'b0010, 3'b001, 3'b110}, // R7 enabled IO clears
        {3'b001, 4'd2, 4'b0010, 3'b001, 3'b110}, // R5 event dropped while held
        {3'b000, 4'd2, 4'b0010, 3'b000, 3'b110}, // R5 stays 0 after release
        {3'b001, 4'd5, 4'b0000, 3'b000, 3'b111}, // R5 event after release sets
        {3'b000, 4'd5, 4'b0000, 3'b100, 3'b011}, // R6 no cross-clear, R9
        {3'b100, 4'd5, 4'b0000, 3'b100, 3'b011}, // R5 compare dropped while held
        {3'b100, 4'd0, 4'b0000, 3'b000, 3'b111}, // R3 compare sets again
        {3'b000, 4'd0, 4'b0000, 3'b100, 3'b010}, // R6 cross-clear hits bit 0
        {3'b000, 4'd0, 4'b0000, 3'b010, 3'b000}, // R4 software clear
        {3'b010, 4'd0, 4'b0000, 3'b010, 3'b000}, // R5 software dropped
        {3'b000, 4'd0, 4'b0000, 3'b000, 3'b000}, // R8 wake low, all clear
        {3'b001, 4'd1, 4'b0000, 3'b000, 3'b001}, // R8 wake from one flag
        {3'b000, 4'd4, 4'b1000, 3'b001, 3'b000}, // R7 last IO line clears
        {3'b001, 4'd0, 4'b0000, 3'b000, 3'b001}, // R2 set with compare selected
        {3'b000, 4'd0, 4'b1111, 3'b001, 3'b001}  // R7 compare code is not IO
    };

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] evt, input logic [3:0] sel,
                         input logic [3:0] ioen, input logic [2:0] clr);
        @(negedge clk);
        {rtc_evt_i, sw_evt_i, prog_evt_i} = evt;
        prog_sel_i = sel;
        io_in_en_i = ioen;
        clr_i      = clr;
        @(posedge clk);
        #1;
        {rtc_evt_i, sw_evt_i, prog_evt_i} = 3'b000;
    endtask

    initial begin
        // R1: events during reset are ignored.
        drive(3'b111, 4'd0, 4'b0000, 3'b000);
        drive(3'b111, 4'd0, 4'b0000, 3'b000);
        check("R1 reset state", flags_o, 3'b000);
        check("R8 wake in reset", {2'b00, wake_req_o}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][16:14], VEC[i][13:10], VEC[i][9:6], VEC[i][5:3]);
            check($sformatf("R1/R2 flags step %0d", i), flags_o, VEC[i][2:0]);
            check($sformatf("R8 wake step %0d", i), {2'b00, wake_req_o},
                  {2'b00, |VEC[i][2:0]});
        end

        // R4: clear held for several cycles with events each cycle.
        drive(3'b110, 4'd5, 4'b0000, 3'b000);
        check("R2 set before hold", flags_o, 3'b111);
        for (int j = 0; j < 4; j++) begin
            drive(3'b100, 4'd5, 4'b0000, 3'b100);
            check("R4 compare held low", flags_o, 3'b011);
        end
        drive(3'b000, 4'd5, 4'b0000, 3'b000);
        check("R5 no event after release", flags_o, 3'b011);

        // R1: synchronous reset mid-run clears all flags.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", flags_o, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'b000, 4'd5, 4'b0000, 3'b000);
        check("R1 stays clear after reset", flags_o, 3'b000);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule